// File: doc/BRIEF.md
# Multi-Mode Sample Capture Buffer

This block stores multi-axis sensor samples in one 32-entry array and releases them oldest first through a show-ahead read port. A two-bit mode input decides what happens to each sample strobe: it goes straight through without being stored, or it is queued until the buffer is full and further samples are dropped, or it is kept in a ring where the newest 32 samples survive, or it is held as a capture window. In the capture window the buffer keeps a programmed number of samples from before a trigger pulse, then fills to the top after the trigger and stops.

A five-bit level input has two uses. In the queue and ring modes it sets the watermark. In capture mode it sets how many pre-trigger samples are kept. The outputs are the entry count (0 to 32), a watermark flag, a sticky overrun flag and a triggered flag. A change of mode costs one idle cycle. In that cycle the sticky flags are cleared, and the stored entries are flushed when the new mode is the pass-through mode.

Top module: `smpbuf_top`

## Requirements
- R1: With mode 00 (pass-through) in effect, no sample is stored, `count_o` stays 0, and `rd_data_o` shows the most recent sample presented with `smp_valid_i`.
- R2: With mode 01 (queue) in effect, samples are appended up to 32 entries. A sample that arrives at a full buffer with no read in the same cycle is dropped and the count stays 32.
- R3: With mode 10 (ring) in effect, a sample that arrives at a full buffer with no read discards the oldest entry. The count stays 32 and the head becomes the next-oldest entry.
- R4: With mode 11 (capture) in effect and no trigger seen yet, at most `level_i` of the newest samples are kept. When the limit is reached, a new sample displaces the oldest. With `level_i` = 0, nothing is stored.
- R5: A `trig_i` pulse while capture mode is in effect sets `trig_done_o` from the next cycle. Samples are then appended until the count reaches 32 and are dropped after that. The flag stays set until the mode changes.
- R6: `wmark_o` is 1 when the mode in effect is not pass-through and `count_o` >= `level_i`. It falls when reads bring the count below the level.
- R7: `ovr_o` rises in the cycle after a sample is lost or overwritten because the buffer is full (queue, ring, or capture after trigger). It stays set until the mode changes.
- R8: In a cycle where `mode_i` differs from the mode in effect, the sample strobe, the read and the trigger are ignored. The new mode takes effect from the next cycle, `ovr_o` and `trig_done_o` clear, and the buffer is emptied if the new mode is 00.
- R9: While `count_o` > 0 and the mode is not pass-through, `rd_data_o` shows the oldest entry and `rd_en_i` removes it at the clock edge. `rd_en_i` at a count of 0 has no effect.
- R10: In queue mode, a read and a sample in the same cycle at a full buffer both take effect. The count stays 32 and no overrun is flagged.
- R11: `count_o` never exceeds 32, and after reset it is 0 with pass-through mode in effect and all flags low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Requested mode: 00 pass-through, 01 queue, 10 ring, 11 capture |
| level_i | input | 5 | Watermark level, or pre-trigger sample count in capture mode |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 48 | Sample: three signed 16-bit axes, x in the top bits |
| trig_i | input | 1 | Trigger event for capture mode |
| rd_en_i | input | 1 | Remove the oldest entry |
| rd_data_o | output | 48 | Oldest entry, or the last sample in pass-through mode |
| count_o | output | 6 | Entries held, 0 to 32 |
| wmark_o | output | 1 | Count at or above level |
| ovr_o | output | 1 | Sticky: a sample was lost or overwritten at full |
| trig_done_o | output | 1 | Trigger seen in capture mode |

## Verification
Several properties are checked on every cycle: the count bound, an empty buffer while pass-through is in effect, the pointer distance matching the count, a held count with overrun when a full queue meets a sample, a held count in the ring on overwrite, and flags cleared and trigger held across mode changes. What the assertions cannot see is which data survives. Only the bench scenarios show oldest-first order after a drop, which head remains after a ring overwrite or a pre-trigger displacement, and the exact fill point after a trigger.

// File: rtl/smpbuf_pkg.sv
package smpbuf_pkg;

    localparam int AXIS_W   = 16;
    localparam int N_AXES   = 3;
    localparam int SAMPLE_W = AXIS_W * N_AXES;

    typedef logic signed [AXIS_W-1:0] axis_t;

    typedef struct packed {
        axis_t x;
        axis_t y;
        axis_t z;
    } sample_t;

    typedef enum logic [1:0] {
        MODE_PASS = 2'b00,
        MODE_HOLD = 2'b01,
        MODE_RING = 2'b10,
        MODE_CAPT = 2'b11
    } buf_mode_e;

    // storage operation issued by the controller each cycle
    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } buf_op_t;

    function automatic logic at_or_above(input logic [7:0] cnt, input logic [7:0] lvl);
        return cnt >= lvl;
    endfunction

endpackage

// File: rtl/smpbuf_mem.sv
module smpbuf_mem
    import smpbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  buf_op_t       op_i,
    input  sample_t       wdata_i,
    output sample_t       head_o,
    output logic [AW-1:0] wptr_o,
    output logic [AW-1:0] rptr_o
);

    sample_t       mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;

    always_ff @(posedge clk) begin
        if (op_i.push && !op_i.flush) begin
            mem[wp_q] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || op_i.flush) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (op_i.push) wp_q <= wp_q + AW'(1);
            if (op_i.pop)  rp_q <= rp_q + AW'(1);
        end
    end

    assign head_o = mem[rp_q];
    assign wptr_o = wp_q;
    assign rptr_o = rp_q;

endmodule

// File: rtl/smpbuf_ctl.sv
module smpbuf_ctl
    import smpbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  buf_mode_e     mode_i,
    input  logic [LW-1:0] level_i,
    input  logic          vld_i,
    input  logic          trig_i,
    input  logic          rd_en_i,
    output buf_op_t       op_o,
    output buf_mode_e     mode_q_o,
    output logic [CW-1:0] count_o,
    output logic          wmark_o,
    output logic          ovr_o,
    output logic          trig_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    buf_mode_e     mode_q;
    logic [CW-1:0] count_q;
    logic          ovr_q;
    logic          trig_q;

    logic          mode_chg;
    logic          rd_ok;
    logic          full;
    logic          ovf;
    logic [CW-1:0] lvl;
    logic [CW-1:0] eff;
    buf_op_t       op;

    assign mode_chg = (mode_i != mode_q);
    assign full     = (count_q == FULL_CNT);
    assign rd_ok    = rd_en_i && (count_q != '0) && (mode_q != MODE_PASS);
    assign lvl      = CW'(level_i);
    assign eff      = count_q - CW'(rd_ok);

    always_comb begin
        op  = '0;
        ovf = 1'b0;
        if (mode_chg) begin
            op.flush = (mode_i == MODE_PASS);
        end else begin
            unique case (mode_q)
                MODE_PASS: begin
                end
                MODE_HOLD: begin
                    op.pop  = rd_ok;
                    op.push = vld_i && (!full || rd_ok);
                    ovf     = vld_i && full && !rd_ok;
                end
                MODE_RING: begin
                    op.push = vld_i;
                    op.pop  = rd_ok || (vld_i && full);
                    ovf     = vld_i && full && !rd_ok;
                end
                MODE_CAPT: begin
                    op.pop = rd_ok;
                    if (trig_q) begin
                        op.push = vld_i && (!full || rd_ok);
                        ovf     = vld_i && full && !rd_ok;
                    end else if (vld_i) begin
                        if (eff < lvl) begin
                            op.push = 1'b1;
                        end else if (lvl != '0 && !rd_ok) begin
                            op.push = 1'b1;
                            op.pop  = 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_PASS;
            count_q <= '0;
            ovr_q   <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            mode_q <= mode_i;
            if (op.flush) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + CW'(op.push) - CW'(op.pop);
            end
            if (mode_chg) begin
                ovr_q  <= 1'b0;
                trig_q <= 1'b0;
            end else begin
                ovr_q <= ovr_q | ovf;
                if (mode_q == MODE_CAPT && trig_i) trig_q <= 1'b1;
            end
        end
    end

    assign op_o     = op;
    assign mode_q_o = mode_q;
    assign count_o  = count_q;
    assign ovr_o    = ovr_q;
    assign trig_o   = trig_q;
    assign wmark_o  = (mode_q != MODE_PASS) && at_or_above(8'(count_q), 8'(lvl));

    // R11: count bound
    p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL_CNT)
        else $error("count above depth");

    // R1: nothing held in pass-through
    p_pass_empty_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PASS) |-> (count_q == '0))
        else $error("entries held in pass-through");

    // R2: full queue drops the sample and flags overrun
    p_hold_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HOLD && !mode_chg && full && vld_i && !rd_en_i)
        |=> (count_q == FULL_CNT && ovr_q))
        else $error("queue did not drop at full");

    // R3: ring overwrite keeps the count at full
    p_ring_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RING && !mode_chg && full && vld_i)
        |=> (count_q == FULL_CNT))
        else $error("ring count changed on overwrite");

    // R8: mode change clears sticky flags
    p_chg_clear_r8: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (!ovr_q && !trig_q))
        else $error("flags survived mode change");

    // R5: trigger flag holds while the mode is unchanged
    p_trig_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (trig_q && !mode_chg) |=> trig_q)
        else $error("trigger flag dropped");

endmodule

// File: rtl/smpbuf_top.sv
module smpbuf_top
    import smpbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic [LW-1:0]       level_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                trig_i,
    input  logic                rd_en_i,
    output logic [SAMPLE_W-1:0] rd_data_o,
    output logic [CW-1:0]       count_o,
    output logic                wmark_o,
    output logic                ovr_o,
    output logic                trig_done_o
);

    buf_op_t       op;
    buf_mode_e     mode_q;
    sample_t       head;
    sample_t       last_q;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count;

    smpbuf_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (buf_mode_e'(mode_i)),
        .level_i  (level_i),
        .vld_i    (smp_valid_i),
        .trig_i   (trig_i),
        .rd_en_i  (rd_en_i),
        .op_o     (op),
        .mode_q_o (mode_q),
        .count_o  (count),
        .wmark_o  (wmark_o),
        .ovr_o    (ovr_o),
        .trig_o   (trig_done_o)
    );

    smpbuf_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .wdata_i (sample_t'(smp_i)),
        .head_o  (head),
        .wptr_o  (wptr),
        .rptr_o  (rptr)
    );

    // pass-through holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
        end else if (smp_valid_i) begin
            last_q <= sample_t'(smp_i);
        end
    end

    assign rd_data_o = (mode_q == MODE_PASS) ? SAMPLE_W'(last_q) : SAMPLE_W'(head);
    assign count_o   = count;

    // R9: pointer distance matches the reported count
    p_ptr_track_r9: assert property (@(posedge clk) disable iff (rst)
        AW'(wptr - rptr) == count[AW-1:0])
        else $error("pointer distance differs from count");

endmodule

// File: tb/sim_smpbuf_top.sv
`timescale 1ns/1ps
module sim_smpbuf_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [4:0]  level = 5'd2;
    logic        smp_valid = 1'b0;
    logic [47:0] smp = '0;
    logic        trig = 1'b0;
    logic        rd_en = 1'b0;
    logic [47:0] rd_data;
    logic [5:0]  count;
    logic        wmark;
    logic        ovr;
    logic        trg_done;

    int checks = 0;
    int errs   = 0;

    always #10 clk = ~clk;

    smpbuf_top u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .level_i(level),
        .smp_valid_i(smp_valid), .smp_i(smp), .trig_i(trig), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .count_o(count), .wmark_o(wmark),
        .ovr_o(ovr), .trig_done_o(trg_done)
    );

    function automatic logic [47:0] mk(input logic [7:0] d);
        return {8'h00, d, 8'h01, d, 8'h02, d};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] d, input logic r, input logic t);
        @(negedge clk);
        smp_valid = v; smp = mk(d); rd_en = r; trig = t;
        @(posedge clk);
        #1;
        smp_valid = 1'b0; rd_en = 1'b0; trig = 1'b0;
    endtask

    task automatic setmode(input logic [1:0] m);
        mode = m;
        step(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    // mode, level, valid, read, trig, data, exp count, exp wmark, exp ovr, exp trig
    typedef struct packed {
        logic [1:0] m;
        logic [4:0] l;
        logic       v;
        logic       r;
        logic       t;
        logic [7:0] d;
        logic [5:0] c;
        logic       wm;
        logic       ov;
        logic       tg;
    } vec_t;

    localparam int NV = 15;
    localparam logic [26:0] TBL [NV] = '{
        {2'd0, 5'd2, 1'b1, 1'b0, 1'b0, 8'h11, 6'd0, 1'b0, 1'b0, 1'b0},
        {2'd1, 5'd2, 1'b1, 1'b0, 1'b0, 8'h21, 6'd0, 1'b0, 1'b0, 1'b0},
        {2'd1, 5'd2, 1'b1, 1'b0, 1'b0, 8'h22, 6'd1, 1'b0, 1'b0, 1'b0},
        {2'd1, 5'd2, 1'b1, 1'b0, 1'b0, 8'h23, 6'd2, 1'b1, 1'b0, 1'b0},
        {2'd1, 5'd2, 1'b0, 1'b1, 1'b0, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0},
        {2'd1, 5'd2, 1'b1, 1'b1, 1'b0, 8'h24, 6'd1, 1'b0, 1'b0, 1'b0},
        {2'd2, 5'd2, 1'b0, 1'b0, 1'b0, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0},
        {2'd2, 5'd2, 1'b1, 1'b0, 1'b0, 8'h30, 6'd2, 1'b1, 1'b0, 1'b0},
        {2'd0, 5'd2, 1'b0, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 1'b0},
        {2'd3, 5'd2, 1'b0, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 1'b0},
        {2'd3, 5'd2, 1'b1, 1'b0, 1'b0, 8'h40, 6'd1, 1'b0, 1'b0, 1'b0},
        {2'd3, 5'd2, 1'b1, 1'b0, 1'b0, 8'h41, 6'd2, 1'b1, 1'b0, 1'b0},
        {2'd3, 5'd2, 1'b1, 1'b0, 1'b0, 8'h42, 6'd2, 1'b1, 1'b0, 1'b0},
        {2'd3, 5'd2, 1'b0, 1'b0, 1'b1, 8'h00, 6'd2, 1'b1, 1'b0, 1'b1},
        {2'd3, 5'd2, 1'b1, 1'b0, 1'b0, 8'h43, 6'd3, 1'b1, 1'b0, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 reset count", 64'(count), 64'd0);
        chk("R11 reset flags", 64'({wmark, ovr, trg_done}), 64'd0);
        chk("R11 reset data", 64'(rd_data), 64'd0);

        // R1 pass-through
        step(1'b1, 8'h05, 1'b0, 1'b0);
        chk("R1 pass data", 64'(rd_data), 64'(mk(8'h05)));
        chk("R1 pass count", 64'(count), 64'd0);

        // vector table: R6 watermark, R8 mode changes, R4/R5 capture
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            mode = v.m;
            level = v.l;
            step(v.v, v.d, v.r, v.t);
            chk($sformatf("R6/R8 row%0d count", i), 64'(count), 64'(v.c));
            chk($sformatf("R6 row%0d wmark", i), 64'(wmark), 64'(v.wm));
            chk($sformatf("R7 row%0d ovr", i), 64'(ovr), 64'(v.ov));
            chk($sformatf("R5 row%0d trig", i), 64'(trg_done), 64'(v.tg));
        end
        chk("R4 displaced head", 64'(rd_data), 64'(mk(8'h41)));

        // queue mode
        setmode(2'd0);
        setmode(2'd1);
        for (int i = 0; i < 32; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        chk("R2 fill count", 64'(count), 64'd32);
        step(1'b1, 8'd100, 1'b1, 1'b0);
        chk("R10 rd+wr count", 64'(count), 64'd32);
        chk("R10 no overrun", 64'(ovr), 64'd0);
        step(1'b1, 8'd101, 1'b0, 1'b0);
        chk("R2 drop count", 64'(count), 64'd32);
        chk("R7 overrun set", 64'(ovr), 64'd1);
        for (int k = 0; k < 32; k++) begin
            chk($sformatf("R9 order %0d", k), 64'(rd_data),
                64'(mk(k < 31 ? 8'(k + 1) : 8'd100)));
            step(1'b0, 8'h00, 1'b1, 1'b0);
        end
        chk("R9 drained", 64'(count), 64'd0);
        chk("R6 wmark low", 64'(wmark), 64'd0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R9 empty read", 64'(count), 64'd0);
        chk("R7 sticky", 64'(ovr), 64'd1);

        // ring mode
        setmode(2'd2);
        chk("R8 ovr cleared", 64'(ovr), 64'd0);
        for (int i = 0; i < 32; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        step(1'b1, 8'd200, 1'b0, 1'b0);
        chk("R3 count", 64'(count), 64'd32);
        chk("R3 head", 64'(rd_data), 64'(mk(8'd1)));
        chk("R7 ring ovr", 64'(ovr), 64'd1);

        // capture mode
        setmode(2'd0);
        chk("R8 flush", 64'(count), 64'd0);
        level = 5'd0;
        setmode(2'd3);
        step(1'b1, 8'd7, 1'b0, 1'b0);
        step(1'b1, 8'd8, 1'b0, 1'b0);
        chk("R4 level0", 64'(count), 64'd0);
        level = 5'd3;
        for (int i = 10; i < 15; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        chk("R4 pre count", 64'(count), 64'd3);
        chk("R4 pre head", 64'(rd_data), 64'(mk(8'd12)));
        step(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R5 trig set", 64'(trg_done), 64'd1);
        for (int i = 50; i < 90; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        chk("R5 fill stop", 64'(count), 64'd32);
        chk("R5 head kept", 64'(rd_data), 64'(mk(8'd12)));
        chk("R7 capt ovr", 64'(ovr), 64'd1);
        setmode(2'd1);
        chk("R8 trig cleared", 64'(trg_done), 64'd0);
        chk("R8 ovr cleared2", 64'(ovr), 64'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule